// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a 16-bit processor that uses real-mode segmentation. It holds four 16-bit segment registers: code, data, stack and extra. For every access it picks one of them. The access kind, the base/index registers used by the addressing mode and an optional prefix override together decide the choice. The chosen segment value, shifted left by four bits, is added to the offset. No limit check or protection check is applied.

The address path is purely combinational. The segment registers are the only state. A write port can reload any segment register in any cycle, and the new value is used from the following cycle on. The block also reports which segment it chose, so the surrounding pipeline can tag the access.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals `{segment, 4'b0000} + offset`, with the carry out of bit 19 discarded, so addresses wrap within 1 MB.
- R2: An access with `acc_kind` = 0 (instruction fetch) always uses the code segment, whatever `addr_mode` and `seg_ovr` hold.
- R3: An access with `acc_kind` = 1 (stack operation) uses the stack segment. A data access (`acc_kind` = 2) whose `addr_mode` is 3 (BP) or 4 (SP) also uses the stack segment.
- R4: A data access with `addr_mode` 0 (BX), 1 (SI), 2 (DI), 6 (BX plus SI or DI) or 7 (direct) uses the data segment. A data access with `addr_mode` 5 (BP plus SI or DI) uses the stack segment.
- R5: A string access (`acc_kind` = 3) uses the extra segment when there is no override.
- R6: On any access other than a fetch, `seg_ovr` values 4, 5, 6 and 7 force the code, data, stack and extra segment respectively. Values 0 to 3 mean no override and leave the implicit choice unchanged.
- R7: A write with `seg_wr_en` high loads `seg_wr_data` into the register that `seg_wr_sel` names. Addresses formed in the same cycle still use the old value, and addresses from the next cycle on use the new value. Registers that are not written keep their value.
- R8: After reset, all four segment registers hold zero.
- R9: `seg_used` reports the segment chosen for the current access, encoded as 0 code, 1 data, 2 stack and 3 extra. `seg_wr_sel` uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment value |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string |
| addr_mode | input | 3 | Base/index registers used by a data access |
| seg_ovr | input | 3 | Prefix override: 0 to 3 none, 4 to 7 code/data/stack/extra |
| offset | input | 16 | Within-segment offset |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment chosen for this access |

## Verification
The assertions check on every cycle that a fetch selects the code segment, that a valid override wins on other accesses, and that a string access with no override selects the extra segment. They also check that a write reaches its register one cycle later, that registers not written hold still, and that the low four address bits pass the offset through unchanged. The implicit rules for each addressing mode, the carry wrap at 1 MB, the reset contents and the same-cycle use of the old segment value need known register contents and specific offsets, so only the bench scenarios show them.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEG_W   = 16;
    localparam int OFS_W   = 16;
    localparam int SHIFT   = 4;
    localparam int PA_W    = 20;
    localparam int NSEG    = 4;
    localparam int SEL_W   = $clog2(NSEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRING = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        AM_BX     = 3'd0,
        AM_SI     = 3'd1,
        AM_DI     = 3'd2,
        AM_BP     = 3'd3,
        AM_SP     = 3'd4,
        AM_BP_IDX = 3'd5,
        AM_BX_IDX = 3'd6,
        AM_DIRECT = 3'd7
    } amode_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int W  = SEG_W,
    parameter int SW = SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_sel,
    input  logic [W-1:0]         wr_data,
    output logic [N-1:0][W-1:0]  bank
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[i] <= '0;
            end else if (wr_en && (wr_sel == SW'(i))) begin
                bank[i] <= wr_data;
            end
        end

        // R7: a register not addressed by the write keeps its value
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SW'(i))) |=> $stable(bank[i]));
    end

    // R7: the written value is present one cycle after the strobe
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  logic [1:0] acc_kind,
    input  logic [2:0] addr_mode,
    input  logic [2:0] seg_ovr,
    output seg_e       sel
);
    seg_e implicit_sel;

    always_comb begin
        unique case (addr_mode)
            AM_BP, AM_SP, AM_BP_IDX:        implicit_sel = SEG_STACK;
            AM_BX, AM_SI, AM_DI,
            AM_BX_IDX, AM_DIRECT:           implicit_sel = SEG_DATA;
            default:                        implicit_sel = SEG_DATA;
        endcase
    end

    always_comb begin
        unique case (acc_kind)
            ACC_FETCH:  sel = SEG_CODE;
            ACC_STACK:  sel = seg_ovr[2] ? seg_e'(seg_ovr[1:0]) : SEG_STACK;
            ACC_DATA:   sel = seg_ovr[2] ? seg_e'(seg_ovr[1:0]) : implicit_sel;
            ACC_STRING: sel = seg_ovr[2] ? seg_e'(seg_ovr[1:0]) : SEG_EXTRA;
            default:    sel = SEG_CODE;
        endcase
    end
endmodule

// File: rtl/seg_adder.sv
module seg_adder
    import seg_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFS_W,
    parameter int SH = SHIFT,
    parameter int AW = PA_W
) (
    input  logic [SW-1:0] seg_val,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] addr
);
    localparam int SUM_W = ((SW + SH) > OW ? (SW + SH) : OW) + 1;

    logic [SUM_W-1:0] full_sum;

    always_comb begin
        full_sum = SUM_W'({seg_val, {SH{1'b0}}}) + SUM_W'(ofs);
        addr     = full_sum[AW-1:0];
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic [1:0]        acc_kind,
    input  logic [2:0]        addr_mode,
    input  logic [2:0]        seg_ovr,
    input  logic [OFS_W-1:0]  offset,
    output logic [PA_W-1:0]   phys_addr,
    output logic [SEL_W-1:0]  seg_used
);
    logic [NSEG-1:0][SEG_W-1:0] bank;
    seg_e                       sel;
    logic [SEG_W-1:0]           cur_seg;

    seg_bank #(.N(NSEG), .W(SEG_W), .SW(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .bank    (bank)
    );

    seg_select u_sel (
        .acc_kind  (acc_kind),
        .addr_mode (addr_mode),
        .seg_ovr   (seg_ovr),
        .sel       (sel)
    );

    always_comb begin
        cur_seg  = bank[sel];
        seg_used = sel;
    end

    seg_adder #(.SW(SEG_W), .OW(OFS_W), .SH(SHIFT), .AW(PA_W)) u_add (
        .seg_val (cur_seg),
        .ofs     (offset),
        .addr    (phys_addr)
    );

    // R2: fetch always lands on the code segment
    a_r2_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_FETCH) |-> (seg_used == SEG_CODE));

    // R6: a valid override wins on every non-fetch access
    a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_FETCH && seg_ovr[2]) |-> (seg_used == seg_ovr[1:0]));

    // R5: string access with no override uses extra
    a_r5_string_extra: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_STRING && !seg_ovr[2]) |-> (seg_used == SEG_EXTRA));

    // R1: the low nibble of the address is the offset's low nibble
    a_r1_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  addr_mode = '0;
    logic [2:0]  seg_ovr = '0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] mdl [4];

    always #2.5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .acc_kind(acc_kind), .addr_mode(addr_mode),
        .seg_ovr(seg_ovr), .offset(offset), .phys_addr(phys_addr), .seg_used(seg_used)
    );

    // {kind, mode, ovr, offset, expected segment}
    localparam logic [25:0] VEC [16] = '{
        {2'd0, 3'd0, 3'd0, 16'h0100, 2'd0},
        {2'd0, 3'd4, 3'd6, 16'hABCD, 2'd0},
        {2'd1, 3'd0, 3'd0, 16'hFFFE, 2'd2},
        {2'd2, 3'd3, 3'd0, 16'h0010, 2'd2},
        {2'd2, 3'd4, 3'd0, 16'h0020, 2'd2},
        {2'd2, 3'd0, 3'd0, 16'h0030, 2'd1},
        {2'd2, 3'd1, 3'd0, 16'h0040, 2'd1},
        {2'd2, 3'd2, 3'd0, 16'h0050, 2'd1},
        {2'd2, 3'd5, 3'd0, 16'h0060, 2'd2},
        {2'd2, 3'd6, 3'd0, 16'h0070, 2'd1},
        {2'd2, 3'd7, 3'd0, 16'h8001, 2'd1},
        {2'd3, 3'd0, 3'd0, 16'h0123, 2'd3},
        {2'd2, 3'd3, 3'd5, 16'h0200, 2'd1},
        {2'd1, 3'd0, 3'd7, 16'h0300, 2'd3},
        {2'd3, 3'd0, 3'd4, 16'h0400, 2'd0},
        {2'd2, 3'd0, 3'd2, 16'h0500, 2'd1}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:               return "R2";
            2, 3, 4:            return "R3";
            5, 6, 7, 8, 9, 10:  return "R4";
            11:                 return "R5";
            default:            return "R6";
        endcase
    endfunction

    function automatic logic [19:0] exp_addr(logic [15:0] s, logic [15:0] o);
        logic [20:0] t;
        t = {1'b0, s, 4'h0} + {5'h0, o};
        return t[19:0];
    endfunction

    task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
        end
    endtask

    task automatic seg_write(logic [1:0] sel, logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        mdl[sel] = val;
    endtask

    task automatic access(logic [1:0] k, logic [2:0] m, logic [2:0] o, logic [15:0] ofs);
        @(negedge clk);
        acc_kind = k; addr_mode = m; seg_ovr = o; offset = ofs;
        #1;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: all segments zero after reset
        for (int s = 0; s < 4; s++) begin
            access(2'd2, 3'd0, 3'(4 + s), 16'h1234);
            chk("R8", phys_addr, 20'h01234);
        end

        seg_write(2'd0, 16'h1000);
        seg_write(2'd1, 16'h2345);
        seg_write(2'd2, 16'h3000);
        seg_write(2'd3, 16'h4000);

        for (int i = 0; i < 16; i++) begin
            logic [1:0] es;
            es = VEC[i][1:0];
            access(VEC[i][25:24], VEC[i][23:21], VEC[i][20:18], VEC[i][17:2]);
            chk(vec_tag(i), phys_addr, exp_addr(mdl[es], VEC[i][17:2]));
            chk("R9", {18'h0, seg_used}, {18'h0, es});
        end

        // R1: carry out of bit 19 is dropped
        seg_write(2'd3, 16'hFFFF);
        access(2'd3, 3'd0, 3'd0, 16'hFFFF);
        chk("R1", phys_addr, 20'h0FFEF);
        access(2'd3, 3'd0, 3'd0, 16'h0010);
        chk("R1", phys_addr, 20'h00000);

        // R7: old value in the write cycle, new value afterwards
        access(2'd2, 3'd0, 3'd0, 16'h0004);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h5000;
        #1;
        chk("R7", phys_addr, exp_addr(16'h2345, 16'h0004));
        @(negedge clk);
        seg_wr_en = 1'b0;
        mdl[1] = 16'h5000;
        #1;
        chk("R7", phys_addr, 20'h50004);
        // R7: the other registers were untouched
        access(2'd0, 3'd0, 3'd0, 16'h0000);
        chk("R7", phys_addr, 20'h10000);
        access(2'd1, 3'd0, 3'd0, 16'h0000);
        chk("R7", phys_addr, 20'h30000);

        // R9: overlapping segments give identical addresses
        seg_write(2'd2, 16'h5000);
        access(2'd1, 3'd0, 3'd0, 16'h0ABC);
        chk("R9", phys_addr, 20'h50ABC);
        chk("R9", {18'h0, seg_used}, 20'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule